// File: doc/BRIEF.md
# Microprocessor Bus Cycle Classifier

This block watches the control strobes of an 8-bit microprocessor bus and samples them once per clock. The strobes are machine-cycle-one, read, write, memory request and I/O request, and all of them are active low. The block also samples the 8-bit data bus and the 16-bit address bus. The strobes and both buses go through the same synchronizer chain, so they stay aligned with each other. The synchronized strobes are decoded into one of seven bus cycle types, and the type of the current sample is kept in a register.

The block compares each new type with the one before it and raises one of three one-clock pulses. A begin pulse marks a change from idle to an active type. An end pulse marks a change from an active type back to idle. An illegal pulse marks a jump from one active type straight to a different active type. The address is latched when a cycle begins, and the data byte is captured on every active sample. When a cycle ends, the end pulse comes with a record holding the type of the cycle that finished, its address and its data byte. A trace collector or a bus monitor can take that record as its input.

Top module: `bus_cycle_classifier`

## Requirements
- R1: The type codes are idle=0, memory read=1, memory write=2, I/O read=3, I/O write=4, opcode fetch=5 and interrupt acknowledge=6. When memory request is low and read is low, the type is fetch if machine-cycle-one is low and memory read otherwise. When memory request is low, read is high and write is low, the type is memory write. The type is reported on `busType`.
- R2: When memory request is low, the I/O request strobe has no effect on the type.
- R3: The I/O request strobe is examined only when memory request is high. I/O request low with machine-cycle-one low gives interrupt acknowledge, whatever the state of read and write. Otherwise, I/O request low with read low gives I/O read, and I/O request low with write low gives I/O write.
- R4: Every other strobe combination gives idle (0). This includes memory request low with both read and write high.
- R5: A bus sample that is set up before a clock edge appears on every output after SYNC_STAGES+1 rising edges. With the defaults this is the third edge.
- R6: `cycBegin` is high for one clock when the type changes from idle to an active type. The address on the bus in that sample is the address that the cycle's record later reports.
- R7: `cycEnd` is high for one clock when the type changes from active to idle. In the same clock, `recType`, `recAddr` and `recData` take the type of the finished cycle, its latched address and the data byte of its last active sample. The record outputs hold their values until the next end.
- R8: `cycIllegal` is high for one clock when the type changes directly between two different active types. No begin or end pulse is raised for that change. The pending address is dropped, so the record that later closes the cycle reports address 0.
- R9: While `rstN` is low at a clock edge, the stored type returns to idle, the synchronizer takes the idle strobe pattern, and all pulses and record outputs go to 0.
- R10: At most one of `cycBegin`, `cycEnd` and `cycIllegal` is high in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Synchronous reset, active low |
| m1N | input | 1 | Machine-cycle-one strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| mreqN | input | 1 | Memory request strobe, active low |
| iorqN | input | 1 | I/O request strobe, active low |
| addrIn | input | 16 | Address bus |
| dataIn | input | 8 | Data bus |
| busType | output | 3 | Type of the most recently classified sample |
| cycBegin | output | 1 | Pulse: a cycle started |
| cycEnd | output | 1 | Pulse: a cycle finished; the record is valid |
| cycIllegal | output | 1 | Pulse: a direct jump between two active types |
| recType | output | 3 | Type of the finished cycle |
| recAddr | output | 16 | Address latched at the start of the finished cycle |
| recData | output | 8 | Last data byte of the finished cycle |

## Verification
The hardest case to reach is an illegal jump that is later followed by a normal end. To check it, the bench must see that no begin or end pulse is raised at the jump itself, and that the record which closes the cycle carries address 0 together with the data of the second type. Random stimulus sometimes holds one active pattern and then switches straight to another without an idle sample in between. Directed sequences force this case on purpose and then put an idle sample after it. Other directed vectors cover the priority corners: both request strobes low at once, memory request low with no read or write, and interrupt acknowledge with read and write also low.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    CYC_NONE   = 3'd0,
    CYC_MEMRD  = 3'd1,
    CYC_MEMWR  = 3'd2,
    CYC_IORD   = 3'd3,
    CYC_IOWR   = 3'd4,
    CYC_FETCH  = 3'd5,
    CYC_INTACK = 3'd6
  } cycType_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic captureData;
    logic emitRecord;
    logic dropPending;
  } dpStrobe_t;

  // memory request is decoded before I/O request
  function automatic cycType_t classifyStrobes(
    input logic m1N, input logic rdN, input logic wrN,
    input logic mreqN, input logic iorqN);
    cycType_t t;
    t = CYC_NONE;
    if (!mreqN) begin
      if (!rdN)      t = m1N ? CYC_MEMRD : CYC_FETCH;
      else if (!wrN) t = CYC_MEMWR;
    end else if (!iorqN) begin
      if (!m1N)      t = CYC_INTACK;
      else if (!rdN) t = CYC_IORD;
      else if (!wrN) t = CYC_IOWR;
    end
    return t;
  endfunction

endpackage

// File: rtl/bcc_sync.sv
module bcc_sync #(
  parameter int WIDTH = 5,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= RESET_VAL;
    else       stage[0] <= dIn;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[i] <= RESET_VAL;
      else       stage[i] <= stage[i-1];
    end
  end

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
  import bcc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      m1N,
  input  logic      rdN,
  input  logic      wrN,
  input  logic      mreqN,
  input  logic      iorqN,
  output cycType_t  prevType,
  output dpStrobe_t dpStrobe,
  output logic      beginPulse,
  output logic      endPulse,
  output logic      illegalPulse
);

  cycType_t curType;
  logic curActive, prevActive;

  assign curType    = classifyStrobes(m1N, rdN, wrN, mreqN, iorqN);
  assign curActive  = (curType != CYC_NONE);
  assign prevActive = (prevType != CYC_NONE);

  always_comb begin
    dpStrobe.latchAddr   = !prevActive && curActive;
    dpStrobe.captureData = curActive;
    dpStrobe.emitRecord  = prevActive && !curActive;
    dpStrobe.dropPending = prevActive && curActive && (curType != prevType);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevType     <= CYC_NONE;
      beginPulse   <= 1'b0;
      endPulse     <= 1'b0;
      illegalPulse <= 1'b0;
    end else begin
      prevType     <= curType;
      beginPulse   <= dpStrobe.latchAddr;
      endPulse     <= dpStrobe.emitRecord;
      illegalPulse <= dpStrobe.dropPending;
    end
  end

  // R10: the three pulses never coincide
  a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({beginPulse, endPulse, illegalPulse}));

  // R6: a begin follows an idle sample
  a_r6_begin_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    beginPulse |-> (prevType != CYC_NONE) && ($past(prevType) == CYC_NONE));

  // R7: an end leaves the bus idle
  a_r7_end_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    endPulse |-> (prevType == CYC_NONE) && ($past(prevType) != CYC_NONE));

  // R8: an illegal jump goes between two different active types
  a_r8_jump_types: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> (prevType != CYC_NONE) && ($past(prevType) != CYC_NONE)
                     && (prevType != $past(prevType)));

endmodule

// File: rtl/bcc_dpath.sv
module bcc_dpath
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStrobe,
  input  cycType_t          prevType,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [DATA_W-1:0] dataS,
  output cycType_t          recType,
  output logic [ADDR_W-1:0] recAddr,
  output logic [DATA_W-1:0] recData
);

  logic [ADDR_W-1:0] addrHold;
  logic [DATA_W-1:0] dataHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHold <= '0;
      dataHold <= '0;
    end else begin
      if (dpStrobe.latchAddr)        addrHold <= addrS;
      else if (dpStrobe.dropPending) addrHold <= '0;
      if (dpStrobe.captureData)      dataHold <= dataS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recType <= CYC_NONE;
      recAddr <= '0;
      recData <= '0;
    end else if (dpStrobe.emitRecord) begin
      recType <= prevType;
      recAddr <= addrHold;
      recData <= dataHold;
    end
  end

  // R8: a dropped cycle holds no address
  a_r8_drop_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(dpStrobe.dropPending) |-> (addrHold == '0));

  // R7: the record holds between ends
  a_r7_record_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dpStrobe.emitRecord) && $past(rstN) |-> $stable(recAddr) && $stable(recData));

endmodule

// File: rtl/bus_cycle_classifier.sv
module bus_cycle_classifier
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m1N,
  input  logic              rdN,
  input  logic              wrN,
  input  logic              mreqN,
  input  logic              iorqN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [2:0]        busType,
  output logic              cycBegin,
  output logic              cycEnd,
  output logic              cycIllegal,
  output logic [2:0]        recType,
  output logic [ADDR_W-1:0] recAddr,
  output logic [DATA_W-1:0] recData
);

  localparam int STB_W = 5;
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [STB_W-1:0] stbS;
  logic [BUS_W-1:0] busS;
  cycType_t  prevType, recTypeE;
  dpStrobe_t dpStrobe;

  bcc_sync #(.WIDTH(STB_W), .STAGES(SYNC_STAGES), .RESET_VAL({STB_W{1'b1}})) u_stbSync (
    .clk(clk), .rstN(rstN), .dIn({m1N, rdN, wrN, mreqN, iorqN}), .dOut(stbS));

  bcc_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RESET_VAL({BUS_W{1'b0}})) u_busSync (
    .clk(clk), .rstN(rstN), .dIn({addrIn, dataIn}), .dOut(busS));

  bcc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .m1N(stbS[4]), .rdN(stbS[3]), .wrN(stbS[2]), .mreqN(stbS[1]), .iorqN(stbS[0]),
    .prevType(prevType), .dpStrobe(dpStrobe),
    .beginPulse(cycBegin), .endPulse(cycEnd), .illegalPulse(cycIllegal));

  bcc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .dpStrobe(dpStrobe), .prevType(prevType),
    .addrS(busS[BUS_W-1:DATA_W]), .dataS(busS[DATA_W-1:0]),
    .recType(recTypeE), .recAddr(recAddr), .recData(recData));

  assign busType = prevType;
  assign recType = recTypeE;

endmodule

// File: tb/bus_cycle_classifier_tb.sv
module bus_cycle_classifier_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic m1N = 1'b1, rdN = 1'b1, wrN = 1'b1, mreqN = 1'b1, iorqN = 1'b1;
  logic [15:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic [2:0]  busType, recType;
  logic        cycBegin, cycEnd, cycIllegal;
  logic [15:0] recAddr;
  logic [7:0]  recData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_cycle_classifier dut_i (
    .clk(clk), .rstN(rstN), .m1N(m1N), .rdN(rdN), .wrN(wrN), .mreqN(mreqN),
    .iorqN(iorqN), .addrIn(addrIn), .dataIn(dataIn), .busType(busType),
    .cycBegin(cycBegin), .cycEnd(cycEnd), .cycIllegal(cycIllegal),
    .recType(recType), .recAddr(recAddr), .recData(recData));

  // strobe vector order {m1, rd, wr, mreq, iorq}, active low
  localparam logic [4:0] S_IDLE   = 5'b11111;
  localparam logic [4:0] S_FETCH  = 5'b00101;
  localparam logic [4:0] S_MEMRD  = 5'b10101;
  localparam logic [4:0] S_MEMWR  = 5'b11001;
  localparam logic [4:0] S_IORD   = 5'b10110;
  localparam logic [4:0] S_IOWR   = 5'b11010;
  localparam logic [4:0] S_INTACK = 5'b01110;

  // reference model state
  int mPrev, mAddr, mData, mRT, mRA, mRD;
  // expectation pipeline, three samples deep
  int eType[3], eBeg[3], eEnd[3], eIll[3], eRT[3], eRA[3], eRD[3];
  bit eV[3];
  string eTag[3];

  function automatic int expType(input logic [4:0] s);
    logic m1, rd, wr, mq, io;
    {m1, rd, wr, mq, io} = s;
    if (mq == 1'b0) begin
      if (rd == 1'b0) return (m1 == 1'b0) ? 5 : 1;
      if (wr == 1'b0) return 2;
      return 0;
    end
    if (io == 1'b0) begin
      if (m1 == 1'b0) return 6;
      if (rd == 1'b0) return 3;
      if (wr == 1'b0) return 4;
    end
    return 0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareHead();
    if (eV[2]) begin
      chk({eTag[2], " (R5 latency)"}, "busType", int'(busType), eType[2]);
      chk("R6", "cycBegin", int'(cycBegin), eBeg[2]);
      chk("R7", "cycEnd", int'(cycEnd), eEnd[2]);
      chk("R8", "cycIllegal", int'(cycIllegal), eIll[2]);
      chk("R7", "recType", int'(recType), eRT[2]);
      chk("R7/R8", "recAddr", int'(recAddr), eRA[2]);
      chk("R7", "recData", int'(recData), eRD[2]);
      chk("R10", "pulse count", int'(cycBegin) + int'(cycEnd) + int'(cycIllegal) <= 1, 1);
    end
  endtask

  task automatic clearModel();
    mPrev = 0; mAddr = 0; mData = 0; mRT = 0; mRA = 0; mRD = 0;
    for (int i = 0; i < 3; i++) eV[i] = 1'b0;
  endtask

  task automatic step(input logic [4:0] s, input logic [15:0] a, input logic [7:0] d,
                      input string tag);
    int cur, b, e, il;
    @(negedge clk);
    compareHead();
    for (int i = 2; i > 0; i--) begin
      eV[i] = eV[i-1]; eType[i] = eType[i-1]; eBeg[i] = eBeg[i-1]; eEnd[i] = eEnd[i-1];
      eIll[i] = eIll[i-1]; eRT[i] = eRT[i-1]; eRA[i] = eRA[i-1]; eRD[i] = eRD[i-1];
      eTag[i] = eTag[i-1];
    end
    {m1N, rdN, wrN, mreqN, iorqN} = s;
    addrIn = a;
    dataIn = d;
    cur = expType(s);
    b  = (mPrev == 0 && cur != 0) ? 1 : 0;
    e  = (mPrev != 0 && cur == 0) ? 1 : 0;
    il = (mPrev != 0 && cur != 0 && cur != mPrev) ? 1 : 0;
    if (e == 1) begin mRT = mPrev; mRA = mAddr; mRD = mData; end
    if (b == 1) mAddr = int'(a);
    if (il == 1) mAddr = 0;
    if (cur != 0) mData = int'(d);
    mPrev = cur;
    eV[0] = 1'b1; eType[0] = cur; eBeg[0] = b; eEnd[0] = e; eIll[0] = il;
    eRT[0] = mRT; eRA[0] = mRA; eRD[0] = mRD; eTag[0] = tag;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(S_IDLE, 16'h0, 8'h0, "R4");
  endtask

  task automatic resetDut();
    @(negedge clk);
    {m1N, rdN, wrN, mreqN, iorqN} = S_IDLE;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "busType in reset", int'(busType), 0);
    chk("R9", "pulses in reset", int'({cycBegin, cycEnd, cycIllegal}), 0);
    chk("R9", "recAddr in reset", int'(recAddr), 0);
    chk("R9", "recData/recType in reset", int'({recData, recType}), 0);
    clearModel();
    rstN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [4:0] pat;
    int seed;
    seed = $urandom(32'h5eed_0042);
    clearModel();
    resetDut();

    // R1: plain memory cycles, with the address changing mid cycle (R6) and data changing (R7)
    step(S_FETCH, 16'h1234, 8'h11, "R1");
    step(S_FETCH, 16'hFFFF, 8'h22, "R6");
    step(S_FETCH, 16'hAAAA, 8'h33, "R7");
    step(S_IDLE,  16'h0000, 8'h44, "R7");
    step(S_MEMWR, 16'hBEEF, 8'h5A, "R1");
    step(S_IDLE,  16'h0000, 8'h00, "R1");
    // R2: both requests low, memory wins
    step(5'b10100, 16'h0F0F, 8'h77, "R2");
    step(S_IDLE,   16'h0000, 8'h00, "R2");
    // R4: memory request low without read or write is idle, even with I/O request low
    step(5'b11100, 16'h0101, 8'h01, "R4");
    step(5'b11101, 16'h0202, 8'h02, "R4");
    // R3: interrupt acknowledge overrides read and write
    step(5'b00010, 16'h00FE, 8'hFF, "R3");
    step(S_IDLE,   16'h0000, 8'h00, "R3");
    step(S_IOWR,   16'h0080, 8'h3C, "R3");
    step(S_IDLE,   16'h0000, 8'h00, "R3");
    // R4: I/O request low with nothing else
    step(5'b11110, 16'h0303, 8'h03, "R4");
    // R8: direct jump then end, record address is 0
    step(S_MEMRD, 16'h4000, 8'h10, "R8");
    step(S_FETCH, 16'h5000, 8'h20, "R8");
    step(S_FETCH, 16'h5001, 8'h21, "R8");
    step(S_IDLE,  16'h0000, 8'h00, "R8");
    // R8: triple jump
    step(S_IORD,  16'h0010, 8'h01, "R8");
    step(S_IOWR,  16'h0011, 8'h02, "R8");
    step(S_INTACK,16'h0012, 8'h03, "R8");
    step(S_IDLE,  16'h0000, 8'h00, "R8");
    flush();

    // R9: reset in the middle of an active cycle
    step(S_MEMRD, 16'h7777, 8'h77, "R9");
    step(S_MEMRD, 16'h7777, 8'h78, "R9");
    resetDut();
    step(S_MEMRD, 16'h8888, 8'h88, "R9");
    step(S_IDLE,  16'h0000, 8'h00, "R9");
    flush();

    // R1: constrained random patterns
    for (int n = 0; n < 600; n++) begin
      int kind, len;
      kind = int'($urandom_range(7, 0));
      len  = int'($urandom_range(4, 1));
      case (kind)
        0: pat = S_IDLE;
        1: pat = S_FETCH;
        2: pat = S_MEMRD;
        3: pat = S_MEMWR;
        4: pat = S_IORD;
        5: pat = S_IOWR;
        6: pat = S_INTACK;
        default: pat = 5'($urandom);
      endcase
      for (int k = 0; k < len; k++)
        step(pat, 16'($urandom), 8'($urandom), "R1");
      if ($urandom_range(3, 0) != 0) step(S_IDLE, 16'($urandom), 8'($urandom), "R4");
    end
    flush();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule